// File: doc/BRIEF.md
# Priority Interrupt Controller Command Decoder

This block is the programming and bookkeeping front end of an eight-line priority interrupt controller. Software reaches it through two byte-wide addresses. Address 0 takes the command that opens an initialization sequence, and it also takes the run-time operation commands. Address 1 loads the line mask in normal operation. While a sequence is open, address 1 instead takes the follow-on setup bytes, which a small step sequencer steers.

The block owns the controller state: the vector base, line mask, in-service set, rotating priority origin, automatic end-of-service and rotate-on-automatic-end flags, the poll request, the read-back selector, special mask mode and special fully nested mode. A separate resolver decides which line wins and presents the result as `win_valid`/`win_line`. This block uses that result at an acknowledge strobe, where it delivers a vector, and at a polled read. Pending bits arrive from the edge capture logic on `pend_in` and are used only for read-back. The `take_o` pulse tells that logic which line has just been accepted.

All accesses are single-cycle strobes. Read data and the delivered vector are registered and appear in the cycle after their strobe.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset, the mask, in-service set, priority origin, special mask and fully nested flags are 0, `init_active_o` is 0, `rdata` is 0 and `vec_valid_o` is 0.
- R2: A write to address 0 with data bit 4 set opens initialization. It clears the mask, in-service set, priority origin, vector base, and the automatic-end, rotate, poll, read-select, special mask and fully nested flags. It raises `init_active_o` and records data bit 0 as "mode byte wanted" and data bit 1 as "single controller".
- R3: The first address-1 write of a sequence stores the data AND 0xF8 as the vector base. Without single mode, the next step is the cascade byte. With single mode, the next step is the mode byte if one is wanted, and normal operation otherwise. The cascade byte leads to the mode byte if one is wanted, and to normal operation otherwise. `init_active_o` stays high until normal operation resumes.
- R4: In the mode-byte step, data bit 4 sets fully nested mode and data bit 1 sets automatic end-of-service. The sequence then ends.
- R5: In normal operation, an address-1 write loads the mask register with the data.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 set requests a poll. Bit 1 set makes bit 0 the read selector (1 = in-service, 0 = pending). Bit 6 set makes bit 5 the special mask flag.
- R7: An address-0 write with bits 4 and 3 clear carries a command code in bits 7:5. Code 1 clears the highest-priority in-service bit, and code 5 does the same and then sets the priority origin to that line + 1. Priority starts at the origin line and falls with each step upward modulo 8. If the in-service set is empty, neither code changes anything.
- R8: Code 3 clears in-service bit (data AND 7). Code 7 does the same and sets the origin to that line + 1. Code 6 sets the origin to (data + 1) AND 7. Codes 0 and 4 set the rotate-on-automatic-end flag to data bit 7. Code 2 changes nothing.
- R9: When a line is accepted, either by an acknowledge strobe with `win_valid` high or by a polled read, one of two things happens. Without automatic end, its in-service bit is set. With automatic end, the in-service set is left as it is, and the origin becomes line + 1 if the rotate flag is set.
- R10: One cycle after an `ack` strobe, `vec_valid_o` is high for one cycle and `vec_o` holds the vector base OR the winning line. If no line wins, it holds the vector base OR 7. `vec_o` holds its value otherwise.
- R11: A read with the poll request set returns, one cycle later, 0x80 OR the winning line and accepts that line as in R9. If no line wins, it returns 0. Every read clears the poll request.
- R12: A read without a poll request returns, one cycle later, the in-service set or `pend_in` at address 0 according to the read selector, and the mask at address 1.
- R13: `take_o` is high in the same cycle as an acknowledge strobe or polled read with `win_valid` high, and `take_line_o` then names the accepted line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ack | input | 1 | Acknowledge strobe from the processor side |
| win_valid | input | 1 | Resolver reports a winning line |
| win_line | input | 3 | Winning line number |
| pend_in | input | 8 | Pending bits from edge capture, for read-back |
| vec_o | output | 8 | Delivered vector |
| vec_valid_o | output | 1 | One-cycle pulse marking a new vector |
| take_o | output | 1 | A line is accepted this cycle |
| take_line_o | output | 3 | Line being accepted |
| mask_o | output | 8 | Mask register |
| isr_o | output | 8 | In-service set |
| prio_base_o | output | 3 | Highest-priority line (rotation origin) |
| special_mask_o | output | 1 | Special mask mode |
| sfn_mode_o | output | 1 | Special fully nested mode |
| init_active_o | output | 1 | Initialization sequence in progress |

## Verification
Most state errors show up on a port one clock edge later. A wrong in-service bit or origin is visible on `isr_o` and `prio_base_o`, and it also changes which line the next end-of-service command clears. A sequencer that is in the wrong step changes `init_active_o` and leaves the mask unloaded. It also leaves the vector base wrong, which shows up in `vec_o` after the next acknowledge. A wrong automatic-end flag, poll flag or read selector is hidden until the next acknowledge or read, where it shows as a missing in-service bit, a wrong `rdata` value, or a `take_o` that should not have fired.

// File: rtl/irqcd_pkg.sv
package irqcd_pkg;

  localparam int IRQ_N  = 8;
  localparam int IRQ_LW = $clog2(IRQ_N);
  localparam int DW     = 8;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_step_t;

  // one-hot bit for a line
  function automatic logic [IRQ_N-1:0] line_bit(input logic [IRQ_LW-1:0] ln);
    line_bit = '0;
    line_bit[ln] = 1'b1;
  endfunction

  // the line that follows ln in rotation
  function automatic logic [IRQ_LW-1:0] next_line(input logic [IRQ_LW-1:0] ln);
    next_line = ln + 1'b1;
  endfunction

  // highest priority set bit counted from origin; {found, line}
  function automatic logic [IRQ_LW:0] top_set(input logic [IRQ_N-1:0] v,
                                               input logic [IRQ_LW-1:0] origin);
    logic [IRQ_LW-1:0] idx;
    top_set = '0;
    for (int k = IRQ_N - 1; k >= 0; k--) begin
      idx = origin + IRQ_LW'(k);
      if (v[idx]) top_set = {1'b1, idx};
    end
  endfunction

  // vector delivered for a line on a given base
  function automatic logic [DW-1:0] make_vec(input logic [DW-1:0] vbase,
                                             input logic [IRQ_LW-1:0] ln);
    make_vec = {vbase[DW-1:IRQ_LW], ln};
  endfunction

endpackage

// File: rtl/irqcd_init_seq.sv
module irqcd_init_seq
  import irqcd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_wr,
  input  logic          want_mode_bit,
  input  logic          single_bit,
  input  logic          step_wr,
  input  logic [DW-1:IRQ_LW] base_bits,
  input  logic          sfn_bit,
  input  logic          aeoi_bit,
  output logic [DW-1:0] vec_base,
  output logic          sfn_mode,
  output logic          aeoi,
  output logic          init_active
);

  init_step_t step_q, step_d;
  logic       want_mode_q, single_q;

  always_comb begin
    step_d = step_q;
    if (step_wr) begin
      unique case (step_q)
        ST_BASE: step_d = single_q ? (want_mode_q ? ST_MODE : ST_RUN) : ST_CASC;
        ST_CASC: step_d = want_mode_q ? ST_MODE : ST_RUN;
        ST_MODE: step_d = ST_RUN;
        default: step_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= ST_RUN;
      want_mode_q <= 1'b0;
      single_q    <= 1'b0;
      vec_base    <= '0;
      sfn_mode    <= 1'b0;
      aeoi        <= 1'b0;
    end else if (open_wr) begin
      step_q      <= ST_BASE;
      want_mode_q <= want_mode_bit;
      single_q    <= single_bit;
      vec_base    <= '0;
      sfn_mode    <= 1'b0;
      aeoi        <= 1'b0;
    end else begin
      step_q <= step_d;
      if (step_wr && step_q == ST_BASE) vec_base <= {base_bits, {IRQ_LW{1'b0}}};
      if (step_wr && step_q == ST_MODE) begin
        sfn_mode <= sfn_bit;
        aeoi     <= aeoi_bit;
      end
    end
  end

  assign init_active = (step_q != ST_RUN);

  // R4
  mode_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_wr && !open_wr && step_q == ST_MODE |=> !init_active && aeoi == $past(aeoi_bit)
      && sfn_mode == $past(sfn_bit));

  // R3
  casc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_wr && !open_wr && step_q == ST_CASC |=> step_q != ST_BASE && step_q != ST_CASC);

endmodule

// File: rtl/irqcd_oper.sv
module irqcd_oper
  import irqcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_clr,
  input  logic              cmd_wr,
  input  logic              mode_wr,
  input  logic              mask_wr,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  input  logic              take,
  input  logic [IRQ_LW-1:0] take_line,
  input  logic              aeoi,
  output logic [IRQ_N-1:0]  mask_q,
  output logic [IRQ_N-1:0]  isr_q,
  output logic [IRQ_LW-1:0] base_q,
  output logic              poll_q,
  output logic              rsel_q,
  output logic              smm_q
);

  logic              rot_q;
  logic [2:0]        cmd;
  logic [IRQ_LW:0]   hit;
  logic              eoi_hit;
  logic [IRQ_LW-1:0] eoi_line;
  logic [IRQ_LW-1:0] arg_line;
  logic [IRQ_N-1:0]  clr_vec, set_vec;
  logic              base_ld, rot_ld, rot_take;
  logic [IRQ_LW-1:0] base_nx;

  assign cmd      = wdata[7:5];
  assign hit      = top_set(isr_q, base_q);
  assign eoi_hit  = hit[IRQ_LW];
  assign eoi_line = hit[IRQ_LW-1:0];
  assign arg_line = wdata[IRQ_LW-1:0];

  always_comb begin
    clr_vec = '0;
    base_ld = 1'b0;
    base_nx = base_q;
    rot_ld  = 1'b0;
    if (cmd_wr) begin
      unique case (cmd)
        3'd0, 3'd4: rot_ld = 1'b1;
        3'd1: if (eoi_hit) clr_vec = line_bit(eoi_line);
        3'd5: if (eoi_hit) begin
          clr_vec = line_bit(eoi_line);
          base_ld = 1'b1;
          base_nx = next_line(eoi_line);
        end
        3'd3: clr_vec = line_bit(arg_line);
        3'd6: begin
          base_ld = 1'b1;
          base_nx = next_line(arg_line);
        end
        3'd7: begin
          clr_vec = line_bit(arg_line);
          base_ld = 1'b1;
          base_nx = next_line(arg_line);
        end
        default: ;
      endcase
    end
  end

  assign set_vec  = (take && !aeoi) ? line_bit(take_line) : '0;
  assign rot_take = take && aeoi && rot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; isr_q <= '0; base_q <= '0;
      rot_q  <= 1'b0; poll_q <= 1'b0; rsel_q <= 1'b0; smm_q <= 1'b0;
    end else if (init_clr) begin
      mask_q <= '0; isr_q <= '0; base_q <= '0;
      rot_q  <= 1'b0; poll_q <= 1'b0; rsel_q <= 1'b0; smm_q <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      isr_q <= (isr_q & ~clr_vec) | set_vec;
      if (base_ld)       base_q <= base_nx;
      else if (rot_take) base_q <= next_line(take_line);
      if (rot_ld) rot_q <= wdata[7];
      if (mode_wr) begin
        if (wdata[2]) poll_q <= 1'b1;
        if (wdata[1]) rsel_q <= wdata[0];
        if (wdata[6]) smm_q  <= wdata[5];
      end
      if (rd_en) poll_q <= 1'b0;
    end
  end

  // R11
  poll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !poll_q);

  // R9
  isr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !aeoi && !init_clr && !cmd_wr |=> isr_q[$past(take_line)]);

  // R9
  aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && aeoi && !init_clr && !cmd_wr |=> isr_q == $past(isr_q));

  // R7
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd == 3'd1 && eoi_hit && !take && !init_clr |=> !isr_q[$past(eoi_line)]);

endmodule

// File: rtl/irqcd_readback.sv
module irqcd_readback
  import irqcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              addr,
  input  logic              poll,
  input  logic              rsel,
  input  logic              win_valid,
  input  logic [IRQ_LW-1:0] win_line,
  input  logic [IRQ_N-1:0]  isr,
  input  logic [IRQ_N-1:0]  pend,
  input  logic [IRQ_N-1:0]  mask,
  input  logic              ack,
  input  logic [DW-1:0]     vec_base,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     vec,
  output logic              vec_valid
);

  logic [DW-1:0] rd_mux, poll_word, vec_nx;

  assign poll_word = win_valid ? {1'b1, {(DW-IRQ_LW-1){1'b0}}, win_line} : '0;
  assign vec_nx    = make_vec(vec_base, win_valid ? win_line : {IRQ_LW{1'b1}});

  always_comb begin
    if (poll)      rd_mux = poll_word;
    else if (addr) rd_mux = mask;
    else           rd_mux = rsel ? isr : pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      vec       <= '0;
      vec_valid <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      if (ack)   vec   <= vec_nx;
      vec_valid <= ack;
    end
  end

  // R10
  vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid && vec[DW-1:IRQ_LW] == $past(vec_base[DW-1:IRQ_LW]));

  // R10
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid && $stable(vec));

  // R11
  spur_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && poll && !win_valid |=> rdata == '0);

endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
  import irqcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              ack,
  input  logic              win_valid,
  input  logic [IRQ_LW-1:0] win_line,
  input  logic [IRQ_N-1:0]  pend_in,
  output logic [DW-1:0]     vec_o,
  output logic              vec_valid_o,
  output logic              take_o,
  output logic [IRQ_LW-1:0] take_line_o,
  output logic [IRQ_N-1:0]  mask_o,
  output logic [IRQ_N-1:0]  isr_o,
  output logic [IRQ_LW-1:0] prio_base_o,
  output logic              special_mask_o,
  output logic              sfn_mode_o,
  output logic              init_active_o
);

  logic wr_lo, wr_hi, open_wr, mode_wr, cmd_wr, mask_wr, step_wr;
  logic poll_q, rsel_q, aeoi_q, take;
  logic [DW-1:0] vec_base_q;

  assign wr_lo   = wr_en && !addr;
  assign wr_hi   = wr_en && addr;
  assign open_wr = wr_lo && wdata[4];
  assign mode_wr = wr_lo && !wdata[4] && wdata[3];
  assign cmd_wr  = wr_lo && !wdata[4] && !wdata[3];
  assign step_wr = wr_hi && init_active_o;
  assign mask_wr = wr_hi && !init_active_o;

  assign take        = win_valid && (ack || (rd_en && poll_q));
  assign take_o      = take;
  assign take_line_o = win_line;

  irqcd_init_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .open_wr       (open_wr),
    .want_mode_bit (wdata[0]),
    .single_bit    (wdata[1]),
    .step_wr       (step_wr),
    .base_bits     (wdata[DW-1:IRQ_LW]),
    .sfn_bit       (wdata[4]),
    .aeoi_bit      (wdata[1]),
    .vec_base      (vec_base_q),
    .sfn_mode      (sfn_mode_o),
    .aeoi          (aeoi_q),
    .init_active   (init_active_o)
  );

  irqcd_oper u_oper (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_clr  (open_wr),
    .cmd_wr    (cmd_wr),
    .mode_wr   (mode_wr),
    .mask_wr   (mask_wr),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .take      (take),
    .take_line (win_line),
    .aeoi      (aeoi_q),
    .mask_q    (mask_o),
    .isr_q     (isr_o),
    .base_q    (prio_base_o),
    .poll_q    (poll_q),
    .rsel_q    (rsel_q),
    .smm_q     (special_mask_o)
  );

  irqcd_readback u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .poll      (poll_q),
    .rsel      (rsel_q),
    .win_valid (win_valid),
    .win_line  (win_line),
    .isr       (isr_o),
    .pend      (pend_in),
    .mask      (mask_o),
    .ack       (ack),
    .vec_base  (vec_base_q),
    .rdata     (rdata),
    .vec       (vec_o),
    .vec_valid (vec_valid_o)
  );

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_wr |=> init_active_o && isr_o == '0 && mask_o == '0 && prio_base_o == '0
      && !special_mask_o && !sfn_mode_o);

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr && !init_active_o |=> mask_o == $past(wdata));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr && init_active_o |=> $stable(mask_o));

  // R13
  take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> win_valid && (ack || rd_en));

endmodule

// File: tb/irq_cmd_decoder_test.sv
`timescale 1ns/1ps
module irq_cmd_decoder_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, wr_en, rd_en, addr, ack, win_valid;
  logic [7:0] wdata, pend_in, rdata, vec_o, mask_o, isr_o;
  logic [2:0] win_line, take_line_o, prio_base_o;
  logic       vec_valid_o, take_o, special_mask_o, sfn_mode_o, init_active_o;

  irq_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack(ack), .win_valid(win_valid),
    .win_line(win_line), .pend_in(pend_in), .vec_o(vec_o),
    .vec_valid_o(vec_valid_o), .take_o(take_o), .take_line_o(take_line_o),
    .mask_o(mask_o), .isr_o(isr_o), .prio_base_o(prio_base_o),
    .special_mask_o(special_mask_o), .sfn_mode_o(sfn_mode_o),
    .init_active_o(init_active_o)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // reference state
  logic [7:0] m_mask, m_isr, m_vbase, m_rdata, m_vec;
  logic [2:0] m_base;
  logic       m_rot, m_poll, m_rsel, m_smm, m_sfnm, m_aeoi, m_ic4, m_single, m_vv;
  int         m_step;

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_top(input logic [7:0] v, input logic [2:0] org);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] l;
      l = 3'((int'(org) + k) % 8);
      if (v[l]) return {1'b1, l};
    end
    return 4'b0;
  endfunction

  function automatic logic [2:0] nxt(input logic [2:0] l);
    return 3'((int'(l) + 1) % 8);
  endfunction

  task automatic model_reset();
    m_mask = 0; m_isr = 0; m_vbase = 0; m_rdata = 0; m_vec = 0; m_base = 0;
    m_rot = 0; m_poll = 0; m_rsel = 0; m_smm = 0; m_sfnm = 0; m_aeoi = 0;
    m_ic4 = 0; m_single = 0; m_vv = 0; m_step = 0;
  endtask

  task automatic cyc(input bit iw, input bit ir, input bit ia, input bit iad,
                     input logic [7:0] d, input bit wv, input logic [2:0] wl,
                     input string tag);
    logic [7:0] o_isr, o_mask, pd;
    logic [2:0] o_base;
    logic       o_poll, o_rsel, o_aeoi, o_rot, tk;
    logic [3:0] h;
    int         o_step;
    pd = 8'($urandom);
    @(negedge clk);
    wr_en = iw; rd_en = ir; ack = ia; addr = iad; wdata = d;
    win_valid = wv; win_line = wl; pend_in = pd;
    o_isr = m_isr; o_mask = m_mask; o_base = m_base; o_poll = m_poll;
    o_rsel = m_rsel; o_aeoi = m_aeoi; o_rot = m_rot; o_step = m_step;
    tk = wv && (ia || (ir && o_poll));
    #1;
    // R13
    chk("R13", "take", {7'b0, take_o}, {7'b0, tk});
    if (tk) chk("R13", "take_line", {5'b0, take_line_o}, {5'b0, wl});
    m_vv = 0;
    if (iw && !iad && d[4]) begin
      model_reset_keep();
      m_step = 1; m_ic4 = d[0]; m_single = d[1];
    end else begin
      if (iw && !iad && d[3]) begin
        if (d[2]) m_poll = 1;
        if (d[1]) m_rsel = d[0];
        if (d[6]) m_smm = d[5];
      end
      if (iw && !iad && !d[3]) begin
        h = ref_top(o_isr, o_base);
        case (d[7:5])
          3'd0, 3'd4: m_rot = d[7];
          3'd1: if (h[3]) m_isr[h[2:0]] = 1'b0;
          3'd5: if (h[3]) begin m_isr[h[2:0]] = 1'b0; m_base = nxt(h[2:0]); end
          3'd3: m_isr[d[2:0]] = 1'b0;
          3'd6: m_base = nxt(d[2:0]);
          3'd7: begin m_isr[d[2:0]] = 1'b0; m_base = nxt(d[2:0]); end
          default: ;
        endcase
      end
      if (iw && iad) begin
        case (o_step)
          0: m_mask = d;
          1: begin m_vbase = d & 8'hF8; m_step = m_single ? (m_ic4 ? 3 : 0) : 2; end
          2: m_step = m_ic4 ? 3 : 0;
          default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_step = 0; end
        endcase
      end
      if (tk) begin
        if (o_aeoi) begin if (o_rot) m_base = nxt(wl); end
        else m_isr[wl] = 1'b1;
      end
    end
    if (ir) begin
      m_poll = 0;
      if (o_poll) m_rdata = wv ? (8'h80 | {5'b0, wl}) : 8'h00;
      else if (iad) m_rdata = o_mask;
      else m_rdata = o_rsel ? o_isr : pd;
    end
    if (ia) begin
      m_vv = 1;
      m_vec = {m_vbase[7:3], wv ? wl : 3'd7};
    end
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; ack = 0;
    chk(tag, "mask", mask_o, m_mask);
    chk(tag, "isr", isr_o, m_isr);
    chk(tag, "origin", {5'b0, prio_base_o}, {5'b0, m_base});
    chk(tag, "smm", {7'b0, special_mask_o}, {7'b0, m_smm});
    chk(tag, "sfnm", {7'b0, sfn_mode_o}, {7'b0, m_sfnm});
    chk(tag, "init", {7'b0, init_active_o}, {7'b0, (m_step != 0)});
    chk(ir ? (o_poll ? "R11" : "R12") : tag, "rdata", rdata, m_rdata);
    chk("R10", "vec_valid", {7'b0, vec_valid_o}, {7'b0, m_vv});
    chk("R10", "vec", vec_o, m_vec);
  endtask

  // clears programmable state, keeps read and vector registers
  task automatic model_reset_keep();
    m_mask = 0; m_isr = 0; m_vbase = 0; m_base = 0; m_rot = 0; m_poll = 0;
    m_rsel = 0; m_smm = 0; m_sfnm = 0; m_aeoi = 0;
  endtask

  task automatic wr(input bit a, input logic [7:0] d, input string tag);
    cyc(1, 0, 0, a, d, bit'($urandom), 3'($urandom), tag);
  endtask
  task automatic rd(input bit a, input bit wv, input logic [2:0] wl, input string tag);
    cyc(0, 1, 0, a, 8'($urandom), wv, wl, tag);
  endtask
  task automatic ak(input bit wv, input logic [2:0] wl, input string tag);
    cyc(0, 0, 1, 0, 8'($urandom), wv, wl, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 0; wr_en = 0; rd_en = 0; ack = 0; addr = 0; wdata = 0;
    win_valid = 0; win_line = 0; pend_in = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mask", mask_o, 8'h00);
    chk("R1", "isr", isr_o, 8'h00);
    chk("R1", "origin", {5'b0, prio_base_o}, 8'h00);
    chk("R1", "init", {7'b0, init_active_o}, 8'h00);
    chk("R1", "rdata", rdata, 8'h00);
    chk("R1", "vec_valid", {7'b0, vec_valid_o}, 8'h00);
    chk("R1", "flags", {6'b0, special_mask_o, sfn_mode_o}, 8'h00);

    // directed: single controller with mode byte, auto end
    wr(0, 8'h13, "R2");
    wr(1, 8'h47, "R3");
    wr(1, 8'h12, "R4");
    ak(0, 3'd0, "R10");
    ak(1, 3'd5, "R9");
    wr(0, 8'h80, "R8");
    ak(1, 3'd5, "R9");
    // cascaded, mode byte, normal end
    wr(0, 8'h11, "R2");
    wr(1, 8'h20, "R3");
    wr(1, 8'h04, "R3");
    wr(1, 8'h00, "R4");
    wr(1, 8'h5A, "R5");
    ak(1, 3'd3, "R9");
    ak(1, 3'd6, "R9");
    wr(0, 8'hC4, "R8");
    wr(0, 8'h20, "R7");
    wr(0, 8'hA0, "R7");
    wr(0, 8'h20, "R7");
    wr(0, 8'h40, "R8");
    wr(0, 8'h0C, "R6");
    rd(0, 0, 3'd0, "R11");
    wr(0, 8'h0C, "R6");
    rd(1, 1, 3'd2, "R11");
    wr(0, 8'h0B, "R6");
    rd(0, 0, 3'd0, "R12");
    rd(1, 0, 3'd0, "R12");
    wr(0, 8'h68, "R6");
    wr(0, 8'hE1, "R8");
    wr(0, 8'h61, "R8");
    // cascaded, no mode byte: two follow-on bytes
    wr(0, 8'h10, "R2");
    wr(1, 8'hFF, "R3");
    wr(1, 8'h00, "R3");
    wr(1, 8'h3C, "R5");

    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] d;
      r = int'($urandom % 100);
      d = 8'($urandom);
      if (r < 2)       wr(0, d | 8'h10, "R2");
      else if (r < 24) wr(1, d, (m_step == 0) ? "R5" : ((m_step == 3) ? "R4" : "R3"));
      else if (r < 44) begin
        d = d & 8'hE7;
        wr(0, d, (d[7:5] == 3'd1 || d[7:5] == 3'd5) ? "R7" : "R8");
      end
      else if (r < 54) wr(0, (d & 8'hE7) | 8'h08, "R6");
      else if (r < 72) rd(bit'($urandom), bit'($urandom), 3'($urandom), "R12");
      else if (r < 94) ak(($urandom % 4) != 0, 3'($urandom), "R9");
      else cyc(0, 0, 0, 0, d, 0, 3'd0, "R10");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule